// File: doc/BRIEF.md
# Unlock Handshake Byte Generator

This block is a bus-master sequencer that produces the byte stream of an unlock (or lock) handshake. One start pulse begins a run. A select input, sampled at that pulse, chooses unlock or lock. The block then presents one byte at a time on an 8-bit data output. Each byte goes out with a single-cycle write strobe whenever the bus side signals ready. After the final write, the block pulses done.

The stream opens with three fixed bytes: 0xFF, 0x00, 0xFF. A run of pseudo-random bytes follows. These come from two 4-bit feedback shift registers, one per nibble, both seeded with all ones, so no table is stored. A state byte then selects the outcome. In unlock mode an acknowledge byte follows it. Address decoding, the processor bus protocol and any checking at the receiving end belong to the surrounding logic.

Top module: `unlock_seq_gen`

## Requirements
- R1: While reset is high, and in the first idle cycle after it, wr_strobe and done are 0, whatever ready is.
- R2: With no run in progress, ready alone produces no write strobe and no done pulse.
- R3: wr_strobe is high only in a cycle where ready is high. Each strobe hands over exactly one byte, and the stream advances to the next byte only on a strobe.
- R4: An unlock run (unlock_sel = 1 at start) writes exactly 17 bytes: FF 00 FF 77 B3 51 A8 D4 62 39 9C 46 2B 15 8A CD EE (hex).
- R5: A lock run (unlock_sel = 0 at start) writes exactly 16 bytes. It matches the unlock stream up to and including 8A, then ends with the state byte 00.
- R6: From the third byte (FF) onward, the next 12 bytes are each derived from the byte before. The upper nibble shifts right by one, with new bit 7 = old bit 7 XOR old bit 4. The lower nibble shifts right by one, with new bit 3 = old bit 1 XOR old bit 0.
- R7: A start pulse during a run is ignored. Neither the stream nor the mode latched at the start of the run changes.
- R8: done is high for exactly one cycle, in the cycle after the strobe of the final byte, and at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when idle |
| unlock_sel | input | 1 | Sampled with start: 1 = unlock, 0 = lock |
| ready | input | 1 | Bus side can take a byte this cycle |
| wr_data | output | 8 | Byte being presented |
| wr_strobe | output | 1 | One-cycle write strobe for wr_data |
| done | output | 1 | One-cycle pulse after the final write |

## Verification
The bench builds the block with its default parameters: 13 shift-register bytes and a lock code of 0x00. These values produce the full 17-byte unlock stream and the 16-byte lock stream, including the wrap of both nibble registers through CD and EE. Each run is driven under several ready patterns: always high, alternating, sparse and pseudo-random. These patterns cover back-to-back strobes as well as long stalls on every byte position. Start pulses with the opposite mode are injected during runs, and ready is also held high with no run in progress.

// File: rtl/unlock_seq_pkg.sv
package unlock_seq_pkg;

    localparam int BYTE_W  = 8;
    localparam int NIB_W   = 4;
    localparam int NIB_CNT = BYTE_W / NIB_W;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [NIB_W-1:0]  nib_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_ZERO,
        PH_PRBS,
        PH_STATE,
        PH_ACK
    } phase_e;

    localparam byte_t LEAD_BYTE = 8'hFF;
    localparam byte_t ZERO_BYTE = 8'h00;
    localparam nib_t  NIB_SEED  = '1;

    // Feedback tap of each nibble register: the top nibble mixes its
    // top and bottom bits, the lower nibble its two bottom bits.
    function automatic int nib_tap(int idx);
        return (idx == NIB_CNT - 1) ? NIB_W - 1 : 1;
    endfunction

    function automatic nib_t nib_next(nib_t cur, int tap);
        return {cur[tap] ^ cur[0], cur[NIB_W-1:1]};
    endfunction

endpackage

// File: rtl/unlock_seq_nibble.sv
module unlock_seq_nibble
    import unlock_seq_pkg::*;
#(
    parameter int TAP = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic step,
    output nib_t q
);

    always_ff @(posedge clk) begin
        if (rst || load) begin
            q <= NIB_SEED;
        end else if (step) begin
            q <= nib_next(q, TAP);
        end
    end

endmodule

// File: rtl/unlock_seq_ctrl.sv
module unlock_seq_ctrl
    import unlock_seq_pkg::*;
#(
    parameter int    PRBS_BYTES = 13,
    parameter byte_t LOCK_CODE  = 8'h00
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    input  logic  unlock_sel,
    input  logic  ready,
    input  byte_t prbs_byte,
    output logic  lfsr_load,
    output logic  lfsr_step,
    output byte_t wr_data,
    output logic  wr_strobe,
    output logic  done,
    output logic  active
);

    localparam int CNT_W = $clog2(PRBS_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PRBS_BYTES - 1);

    phase_e           phase;
    logic             mode_unlock;
    logic [CNT_W-1:0] cnt;
    logic             last_write;

    assign active    = (phase != PH_IDLE);
    assign wr_strobe = active && ready;
    assign lfsr_load = !active && start;
    assign lfsr_step = wr_strobe &&
                       ((phase == PH_PRBS) || ((phase == PH_STATE) && mode_unlock));
    assign last_write = wr_strobe &&
                        ((phase == PH_ACK) || ((phase == PH_STATE) && !mode_unlock));

    always_comb begin
        unique case (phase)
            PH_LEAD:  wr_data = LEAD_BYTE;
            PH_ZERO:  wr_data = ZERO_BYTE;
            PH_PRBS:  wr_data = prbs_byte;
            PH_STATE: wr_data = mode_unlock ? prbs_byte : LOCK_CODE;
            PH_ACK:   wr_data = prbs_byte;
            default:  wr_data = ZERO_BYTE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_IDLE;
            mode_unlock <= 1'b0;
            cnt         <= '0;
            done        <= 1'b0;
        end else begin
            done <= last_write;
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase       <= PH_LEAD;
                        mode_unlock <= unlock_sel;
                        cnt         <= '0;
                    end
                end
                PH_LEAD: if (wr_strobe) phase <= PH_ZERO;
                PH_ZERO: if (wr_strobe) phase <= PH_PRBS;
                PH_PRBS: begin
                    if (wr_strobe) begin
                        if (cnt == CNT_LAST) begin
                            phase <= PH_STATE;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                PH_STATE: if (wr_strobe) phase <= mode_unlock ? PH_ACK : PH_IDLE;
                PH_ACK:   if (wr_strobe) phase <= PH_IDLE;
                default:  phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/unlock_seq_gen.sv
module unlock_seq_gen
    import unlock_seq_pkg::*;
#(
    parameter int    PRBS_BYTES = 13,
    parameter byte_t LOCK_CODE  = 8'h00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  logic       unlock_sel,
    input  logic       ready,
    output logic [7:0] wr_data,
    output logic       wr_strobe,
    output logic       done
);

    byte_t prbs_byte;
    logic  lfsr_load;
    logic  lfsr_step;
    logic  run_active;

    for (genvar g = 0; g < NIB_CNT; g++) begin : g_nib
        unlock_seq_nibble #(
            .TAP(nib_tap(g))
        ) i_nib (
            .clk (clk),
            .rst (rst),
            .load(lfsr_load),
            .step(lfsr_step),
            .q   (prbs_byte[g*NIB_W +: NIB_W])
        );
    end

    unlock_seq_ctrl #(
        .PRBS_BYTES(PRBS_BYTES),
        .LOCK_CODE (LOCK_CODE)
    ) i_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .unlock_sel(unlock_sel),
        .ready     (ready),
        .prbs_byte (prbs_byte),
        .lfsr_load (lfsr_load),
        .lfsr_step (lfsr_step),
        .wr_data   (wr_data),
        .wr_strobe (wr_strobe),
        .done      (done),
        .active    (run_active)
    );

endmodule

// File: rtl/unlock_seq_gen_chk.sv
module unlock_seq_gen_chk (
    input logic       clk,
    input logic       rst,
    input logic       ready,
    input logic [7:0] wr_data,
    input logic       wr_strobe,
    input logic       done,
    input logic       run_active
);

    a_r3_strobe_needs_ready: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |-> ready);

    a_r2_no_strobe_idle: assert property (@(posedge clk) disable iff (rst)
        !run_active |-> !wr_strobe);

    a_r4_lead_byte: assert property (@(posedge clk) disable iff (rst)
        $rose(run_active) |-> (wr_data == 8'hFF));

    a_r8_done_follows_write: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(wr_strobe));

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !run_active);

endmodule

bind unlock_seq_gen unlock_seq_gen_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .ready     (ready),
    .wr_data   (wr_data),
    .wr_strobe (wr_strobe),
    .done      (done),
    .run_active(run_active)
);

// File: tb/test_unlock_seq_gen.sv
`timescale 1ns/1ps
module test_unlock_seq_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       unlock_sel = 1'b0;
    logic       ready = 1'b0;
    logic [7:0] wr_data;
    logic       wr_strobe;
    logic       done;

    int         n_cmp = 0;
    int         n_bad = 0;
    int         done_total = 0;
    int         strobe_total = 0;
    bit         last_popped = 1'b0;
    bit         finished = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [15:0] rnd = 16'hACE1;

    always #10 clk = ~clk;

    unlock_seq_gen i_unlock_seq_gen (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .unlock_sel(unlock_sel),
        .ready     (ready),
        .wr_data   (wr_data),
        .wr_strobe (wr_strobe),
        .done      (done)
    );

    function automatic logic [7:0] next_byte(logic [7:0] b);
        return {b[7] ^ b[4], b[7:5], b[1] ^ b[0], b[3:1]};
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic push(logic [7:0] b, string tag);
        exp_q.push_back(b);
        tag_q.push_back(tag);
    endtask

    task automatic push_run(bit unl);
        logic [7:0] b;
        push(8'hFF, "R4");
        push(8'h00, "R4");
        b = 8'hFF;
        for (int i = 0; i < 13; i++) begin
            push(b, "R6");
            b = next_byte(b);
        end
        if (unl) begin
            push(8'hCD, "R4");
            push(8'hEE, "R4");
        end else begin
            push(8'h00, "R5");
        end
    endtask

    function automatic logic pat_bit(int pat, int c);
        case (pat)
            0:       return 1'b1;
            1:       return c[0];
            2:       return rnd[0];
            default: return (c % 3) == 0;
        endcase
    endfunction

    // Monitor: compares each write against the scoreboard queue.
    always @(negedge clk) begin
        if (!rst) begin
            if (done || last_popped)
                check(done == last_popped, "R8", "done vs final write", done, last_popped);
            if (done) done_total++;
            last_popped = 1'b0;
            if (wr_strobe) begin
                strobe_total++;
                check(ready == 1'b1, "R3", "strobe without ready", ready, 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected write", wr_data, 0);
                end else begin
                    logic [7:0] e;
                    string      t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(wr_data == e, t, "write data", wr_data, e);
                    if (exp_q.size() == 0) last_popped = 1'b1;
                end
            end
        end
    end

    task automatic run(bit unl, int pat, bit poke);
        int d0;
        int c;
        d0 = done_total;
        push_run(unl);
        @(posedge clk) #2;
        start = 1'b1;
        unlock_sel = unl;
        ready = pat_bit(pat, 0);
        @(posedge clk) #2;
        start = 1'b0;
        c = 1;
        while (done_total == d0) begin
            rnd = {rnd[14:0], rnd[15] ^ rnd[13] ^ rnd[12] ^ rnd[10]};
            ready = pat_bit(pat, c);
            if (poke && (c == 6 || c == 20)) begin
                start = 1'b1;      // R7: ignored during a run
                unlock_sel = !unl;
            end else begin
                start = 1'b0;
            end
            @(posedge clk) #2;
            c++;
        end
        start = 1'b0;
        ready = 1'b0;
        check(exp_q.size() == 0, unl ? "R4" : "R5", "bytes left over", exp_q.size(), 0);
        check(done_total == d0 + 1, "R8", "done count", done_total, d0 + 1);
    endtask

    initial begin
        int s0;
        int d0;
        ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(wr_strobe == 1'b0, "R1", "strobe in reset", wr_strobe, 0);
        check(done == 1'b0, "R1", "done in reset", done, 0);
        @(posedge clk) #2;
        rst = 1'b0;
        @(negedge clk);
        check(wr_strobe == 1'b0, "R1", "strobe after reset", wr_strobe, 0);
        check(done == 1'b0, "R1", "done after reset", done, 0);

        // R2: ready with no run
        s0 = strobe_total;
        d0 = done_total;
        repeat (20) @(posedge clk);
        @(negedge clk);
        check(strobe_total == s0, "R2", "strobes while idle", strobe_total, s0);
        check(done_total == d0, "R2", "done while idle", done_total, d0);
        ready = 1'b0;

        run(1'b1, 0, 1'b0);   // R4 back-to-back
        run(1'b0, 0, 1'b0);   // R5
        run(1'b1, 1, 1'b0);   // R3 alternating stalls
        run(1'b0, 3, 1'b0);
        run(1'b1, 2, 1'b0);
        run(1'b0, 2, 1'b0);
        run(1'b1, 1, 1'b1);   // R7 restart attempt, opposite mode
        run(1'b0, 0, 1'b1);   // R7

        // R2 again after runs
        s0 = strobe_total;
        ready = 1'b1;
        repeat (10) @(posedge clk);
        @(negedge clk);
        check(strobe_total == s0, "R2", "strobes after runs", strobe_total, s0);
        ready = 1'b0;

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            check(1'b0, "R8", "watchdog expired, run never completed", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule